// File: doc/BRIEF.md
# Edge-Timed Period Capture Channel

This block is one channel of a timer subsystem. It watches a single input pin and, on each edge of the chosen polarity, takes a snapshot of a shared 16-bit free-running counter bus. The newest snapshot is kept in capture register A. The snapshot it replaces goes to a hidden staging register, and from there to the visible older-capture register B. Software reads A and B and takes their difference to get the time between two like edges. The block also outputs that difference directly, computed modulo 2^16, so a counter wrap between the two edges still gives the right period.

Two modes use this path. Period mode does not raise the event flag on the first edge after it is armed. It raises the flag on every later edge. Capture mode raises the flag on every edge, including the first, and software may ignore B in this mode. The flag stays set until software pulses a clear input. When a 32-bit coherent read of the capture pair is in progress, the move from the staging register into B waits until the read is over. This keeps the B half of the read from being torn. All ports are plain control and status signals: there is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `period_capture_channel`

## Requirements
- R1: After reset, cap_a, cap_b and flag are all 0, and the first-edge tracking is cleared.
- R2: pin_in passes through two synchronizer flip-flops, and pin_level equals the value pin_in had two clock edges earlier.
- R3: With cfg_fall = 0, only rising edges of the synchronized pin capture. With cfg_fall = 1, only falling edges capture. An edge of the other polarity leaves cap_a unchanged.
- R4: A qualifying edge is seen one clock after pin_level changes. On that clock, cap_a loads the value on cnt_bus and the hidden staging register takes the old cap_a. On the next clock, cap_b takes the staged value.
- R5: If coh_busy is high when an edge other than the first is captured, cap_b holds its value. It loads the staged value on the first clock after coh_busy goes low.
- R6: In period mode (cfg_mode = 4'b0010), the first captured edge after arming leaves flag unchanged, and every later captured edge sets flag.
- R7: In capture mode (cfg_mode = 4'b0011), every captured edge sets flag, including the first.
- R8: flag stays 1 until flag_clr is high at a clock edge. When an edge sets flag in the same cycle that flag_clr is high, the set wins.
- R9: Any cfg_mode value other than 4'b0010 and 4'b0011 disables capture: cap_a, cap_b and flag do not change on edges.
- R10: period equals cap_a minus cap_b, modulo 2^16.
- R11: Any change of cfg_mode re-arms the first-edge tracking, so the next captured edge is treated as the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 4 | Mode select: 0010 period, 0011 capture, any other value disabled |
| cfg_fall | input | 1 | Edge polarity: 0 rising, 1 falling |
| flag_clr | input | 1 | Software clear for flag |
| cnt_bus | input | 16 | Shared free-running counter value |
| pin_in | input | 1 | Asynchronous input pin |
| coh_busy | input | 1 | A coherent 32-bit read of the capture pair is in progress |
| cap_a | output | 16 | Newest capture |
| cap_b | output | 16 | Older capture, visible to software |
| period | output | 16 | cap_a minus cap_b, modulo 2^16 |
| flag | output | 1 | Sticky event flag |
| pin_level | output | 1 | Synchronized pin level |

## Verification
Two functions can fall in the same clock. The first pair is a flag-setting capture and a software flag clear. The bench schedules flag_clr so that it is high on exactly the clock that captures a non-first edge, starting from a cleared flag. It then requires flag to read 1 and to stay at 1 until a later clear on its own. The second pair is a capture and a coherent read. The bench holds coh_busy across a non-first capture and requires cap_a to update at once, while cap_b keeps its old value until the clock after coh_busy drops.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_PERIOD  = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_CAPTURE = 4'b0011;

  function automatic logic mode_enabled(input logic [MODE_W-1:0] m);
    return (m == MODE_PERIOD) || (m == MODE_CAPTURE);
  endfunction
endpackage

// File: rtl/pcc_edge_sync.sv
module pcc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic fall_sel,
  output logic level,
  output logic edge_hit
);
  logic [STAGES-1:0] sh;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) sh[g] <= 1'b0;
        else if (g == 0) sh[g] <= pin_in;
        else sh[g] <= sh[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else last_q <= sh[STAGES-1];
  end

  assign level    = sh[STAGES-1];
  assign edge_hit = fall_sel ? (last_q & ~level) : (level & ~last_q);
endmodule

// File: rtl/pcc_capture_regs.sv
module pcc_capture_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic         cap_first,
  input  logic [W-1:0] bus,
  input  logic         coh_busy,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b2_q
);
  logic [W-1:0] b1_q;
  logic         pend_q;
  logic         pend_first_q;
  logic         xfer;

  assign xfer = pend_q && (!coh_busy || pend_first_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q          <= '0;
      b1_q         <= '0;
      b2_q         <= '0;
      pend_q       <= 1'b0;
      pend_first_q <= 1'b0;
    end else if (cap) begin
      a_q          <= bus;
      b1_q         <= a_q;
      pend_q       <= 1'b1;
      pend_first_q <= cap_first;
    end else if (xfer) begin
      b2_q         <= b1_q;
      pend_q       <= 1'b0;
      pend_first_q <= 1'b0;
    end
  end

  AST_B_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (coh_busy && !pend_first_q && !(cap && cap_first)) |=> $stable(b2_q)); // R5
endmodule

// File: rtl/pcc_flag_ctrl.sv
module pcc_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic cap_first,
  input  logic capture_mode,
  input  logic clr,
  output logic flag_q
);
  logic set_ev;

  assign set_ev = cap && (!cap_first || capture_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (set_ev) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R8
  AST_PERIOD_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && cap_first && !capture_mode && !flag_q) |=> !flag_q); // R6
  AST_CAPTURE_FIRST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && capture_mode) |=> flag_q); // R7
endmodule

// File: rtl/period_capture_channel.sv
module period_capture_channel
  import pcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_fall,
  input  logic              flag_clr,
  input  logic [CNT_W-1:0]  cnt_bus,
  input  logic              pin_in,
  input  logic              coh_busy,
  output logic [CNT_W-1:0]  cap_a,
  output logic [CNT_W-1:0]  cap_b,
  output logic [CNT_W-1:0]  period,
  output logic              flag,
  output logic              pin_level
);
  logic [MODE_W-1:0] mode_q;
  logic              armed_q;
  logic              mode_chg;
  logic              cap_en;
  logic              edge_hit;
  logic              cap;
  logic              cap_first;

  assign mode_chg  = (cfg_mode != mode_q);
  assign cap_en    = mode_enabled(cfg_mode);
  assign cap       = edge_hit && cap_en;
  assign cap_first = !armed_q || mode_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      mode_q <= cfg_mode;
      if (cap) armed_q <= 1'b1;
      else if (mode_chg) armed_q <= 1'b0;
    end
  end

  pcc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .fall_sel(cfg_fall),
    .level(pin_level), .edge_hit(edge_hit)
  );

  pcc_capture_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cap(cap), .cap_first(cap_first),
    .bus(cnt_bus), .coh_busy(coh_busy), .a_q(cap_a), .b2_q(cap_b)
  );

  pcc_flag_ctrl u_flag (
    .clk(clk), .rst_n(rst_n), .cap(cap), .cap_first(cap_first),
    .capture_mode(cfg_mode == MODE_CAPTURE), .clr(flag_clr), .flag_q(flag)
  );

  assign period = cap_a - cap_b;

  AST_DISABLED_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(cap_a)); // R9
  AST_CAPTURE_LOADS_A: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (cap_a == $past(cnt_bus))); // R4
endmodule

// File: tb/period_capture_channel_test.sv
module period_capture_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_mode = 4'd0;
  logic        cfg_fall = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] cnt_bus = 16'd0;
  logic        pin_in = 1'b0;
  logic        coh_busy = 1'b0;
  logic [15:0] cap_a, cap_b, period;
  logic        flag, pin_level;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_a = 16'd0;
  logic [15:0] exp_b = 16'd0;

  always #5 clk = ~clk;

  period_capture_channel uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_fall(cfg_fall),
    .flag_clr(flag_clr), .cnt_bus(cnt_bus), .pin_in(pin_in), .coh_busy(coh_busy),
    .cap_a(cap_a), .cap_b(cap_b), .period(period), .flag(flag), .pin_level(pin_level)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_at(input logic [15:0] v);
    @(negedge clk);
    cnt_bus = v;
    pin_in  = ~cfg_fall;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    pin_in = cfg_fall;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic capture_and_check(input logic [15:0] v, input logic exp_flag, input string req);
    edge_at(v);
    exp_b = exp_a;
    exp_a = v;
    chk({req, " A"}, cap_a, exp_a);
    chk({req, " B"}, cap_b, exp_b);
    chk({req, " flag"}, {15'd0, flag}, {15'd0, exp_flag});
    chk("R10 period", period, exp_a - exp_b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset A", cap_a, 16'd0);
    chk("R1 reset B", cap_b, 16'd0);
    chk("R1 reset flag", {15'd0, flag}, 16'd0);

    pin_in = 1'b1;
    @(negedge clk);
    chk("R2 sync stage1", {15'd0, pin_level}, 16'd0);
    @(negedge clk);
    chk("R2 sync stage2", {15'd0, pin_level}, 16'd1);
    pin_in = 1'b0;
    repeat (3) @(negedge clk);

    for (int m = 0; m < 16; m++) begin
      if (m == 2 || m == 3) continue;
      @(negedge clk);
      cfg_mode = m[3:0];
      edge_at(16'h1111 + m[15:0]);
      chk("R9 disabled A", cap_a, 16'd0);
      chk("R9 disabled flag", {15'd0, flag}, 16'd0);
      idle();
    end

    @(negedge clk);
    cfg_mode = 4'b0010;
    for (int i = 0; i < 10; i++) begin
      logic [15:0] v;
      v = 16'hE000 + 16'(i) * 16'h1357;
      capture_and_check(v, (i != 0), (i == 0) ? "R6 first" : "R4 R6 later");
      idle();
      chk("R3 wrong polarity A", cap_a, exp_a);
      clear_flag();
      chk("R8 cleared", {15'd0, flag}, 16'd0);
    end

    @(negedge clk);
    cfg_fall = 1'b1;
    for (int i = 0; i < 3; i++) begin
      idle();
      chk("R3 rise ignored when falling", cap_a, exp_a);
      capture_and_check(16'h3000 + 16'(i) * 16'h0101, 1'b1, "R3 falling");
      clear_flag();
    end

    @(negedge clk);
    cfg_fall = 1'b0;
    cfg_mode = 4'b0011;
    capture_and_check(16'h4242, 1'b1, "R7 R11 capture first");
    idle();
    clear_flag();
    capture_and_check(16'h4300, 1'b1, "R7 capture later");
    idle();
    clear_flag();

    @(negedge clk);
    cfg_mode = 4'b0010;
    capture_and_check(16'h5000, 1'b0, "R11 rearm");
    idle();
    capture_and_check(16'h5A00, 1'b1, "R6 after rearm");
    idle();
    clear_flag();

    @(negedge clk);
    coh_busy = 1'b1;
    edge_at(16'h6100);
    chk("R5 A during busy", cap_a, 16'h6100);
    chk("R5 B held", cap_b, exp_b);
    repeat (3) @(negedge clk);
    chk("R5 B still held", cap_b, exp_b);
    coh_busy = 1'b0;
    @(negedge clk);
    exp_b = exp_a;
    exp_a = 16'h6100;
    chk("R5 B after busy", cap_b, exp_b);
    chk("R10 period after busy", period, exp_a - exp_b);
    idle();
    clear_flag();

    @(negedge clk);
    cnt_bus = 16'h7777;
    pin_in  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R8 set wins over clear", {15'd0, flag}, 16'd1);
    chk("R4 concurrent A", cap_a, 16'h7777);
    repeat (5) @(negedge clk);
    chk("R8 sticky", {15'd0, flag}, 16'd1);
    clear_flag();
    chk("R8 clear alone", {15'd0, flag}, 16'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule